// File: doc/BRIEF.md
# Watchdog and Stop-Mode Reset Controller

This block decides when a small controller core may execute. It owns the internal active-low system reset, the oscillator enable and the run enable. A 14-stage watchdog counter advances on a divided tick (one pulse every 48 oscillator cycles). If software fails to clear it within 2^13 ticks, the block issues a reset pulse 16 ticks long. The same counter also times the release of reset after power-on and after a low-supply event: reset stays low until the counter has run a full 2^13 ticks from clear.

A stop strobe from the core parks the device. The oscillator enable drops, the run enable drops and the watchdog is held at zero. The stop is accepted only when every active-low wake line is high; if any line is already low, the strobe does nothing. Any wake line going low ends the stop. The oscillator is then re-enabled, and a dedicated stabilisation counter waits 2^10 ticks before execution resumes, with the watchdog restarting from zero. The wake lines are asynchronous and pass through a two-flop synchroniser.

All ports are plain control levels or strobes, so no valid/ready handshake applies. The power-on input is an asynchronous active-high reset for the whole block.

Top module: `wdg_stop_rstctl`

## Requirements
- R1: While `por_i` is high, the outputs are `sys_rst_n_o`=0, `run_en_o`=0, `osc_en_o`=1 and `port_stop_o`=0.
- R2: After `por_i` falls, `sys_rst_n_o` stays 0 through 2^13-1 ticks. It rises, together with `run_en_o`, at the clock edge that samples the 2^13-th tick.
- R3: While running, if 2^13 ticks arrive with no clear, `sys_rst_n_o` and `run_en_o` fall at the edge that samples the 2^13-th tick.
- R4: A cycle with `wdt_clr_i`=1 while running zeroes the watchdog, so a timeout needs a further full 2^13 ticks. Cycles with `tick_i`=0 never advance any count.
- R5: A watchdog reset lasts exactly 16 ticks. Execution then resumes, and the watchdog restarts from zero.
- R6: `lvd_i`=1 forces `sys_rst_n_o`=0 at the next edge. Reset stays asserted whatever ticks arrive while `lvd_i` is high. After `lvd_i` falls, reset releases only after 2^13 further ticks.
- R7: A stop strobe with all wake lines high puts the block in stop at the next edge: `port_stop_o`=1, `osc_en_o`=0, `run_en_o`=0. While stopped, ticks are ignored and no watchdog reset occurs.
- R8: A stop strobe while any wake line has been low for at least two cycles has no effect: `run_en_o` stays 1 and `port_stop_o` stays 0.
- R9: In stop, a wake line going low is seen after a two-flop synchroniser, and stop ends at the third edge: `osc_en_o`=1, `port_stop_o`=0, `run_en_o`=0. `run_en_o` rises at the edge sampling the 2^10-th tick after that.
- R10: After wake-up, the watchdog counts from zero: the first timeout falls at the 2^13-th tick after `run_en_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| por_i | input | 1 | Power-on pulse, asynchronous active-high block reset |
| tick_i | input | 1 | One-cycle strobe at fosc/48 |
| wdt_clr_i | input | 1 | Watchdog clear instruction strobe |
| stop_req_i | input | 1 | Stop instruction strobe |
| lvd_i | input | 1 | Low-supply detect level, high while supply is low |
| wake_n_i | input | WAKE_W | Active-low wake/key lines, asynchronous |
| sys_rst_n_o | output | 1 | Internal system reset, active low, registered |
| osc_en_o | output | 1 | Oscillator enable, registered |
| run_en_o | output | 1 | Core run enable, registered |
| port_stop_o | output | 1 | High while in stop mode, registered |

## Verification
The bench drives ticks with random idle gaps. It then checks reset release and timeout on the exact tick that completes the count. A counter that also advanced on idle cycles, or that was off by one, would move the edge by one or more ticks. A low-supply phase with more ticks than the timeout catches a counter that is not held clear, because release would then come early. A stop run with thousands of ticks would show a reset in stop if the watchdog kept counting. A stop strobe issued with a key already held low would leave the core halted if the no-op case were missing. After wake-up, a watchdog not restarted from zero would time out before the 2^13-th tick.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [2:0] {
    ST_LOWV,
    ST_RELEASE,
    ST_RUN,
    ST_WDRST,
    ST_STOP,
    ST_STAB
  } rsc_state_e;
endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         por_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or posedge por_i) begin
        if (por_i) pipe[s] <= '1;
        else if (s == 0) pipe[s] <= d_i;
        else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/rsc_counter.sv
module rsc_counter #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         por_i,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk or posedge por_i) begin
    if (por_i)      cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/rsc_seq.sv
module rsc_seq
  import rsc_pkg::*;
#(
  parameter int WDT_BITS  = 14,
  parameter int STAB_BIT  = 10,
  parameter int RST_TICKS = 16
) (
  input  logic                clk,
  input  logic                por_i,
  input  logic                lvd_i,
  input  logic                tick_i,
  input  logic                wdt_clr_i,
  input  logic                stop_req_i,
  input  logic                wake_idle_i,
  input  logic [WDT_BITS-1:0] wdt_cnt_i,
  input  logic [STAB_BIT:0]   stab_cnt_i,
  output logic                wdt_clr_o,
  output logic                wdt_inc_o,
  output logic                stab_clr_o,
  output logic                stab_inc_o,
  output logic                sys_rst_n_o,
  output logic                osc_en_o,
  output logic                run_en_o,
  output logic                port_stop_o
);
  localparam logic [WDT_BITS-1:0] WDT_TOP   = WDT_BITS'((1 << (WDT_BITS-1)) - 1);
  localparam logic [WDT_BITS-1:0] PULSE_TOP = WDT_BITS'(RST_TICKS - 1);
  localparam logic [STAB_BIT:0]   STAB_TOP  = (STAB_BIT+1)'((1 << STAB_BIT) - 1);

  rsc_state_e state, state_nxt;

  always_comb begin
    state_nxt = state;
    if (lvd_i) begin
      state_nxt = ST_LOWV;
    end else begin
      unique case (state)
        ST_LOWV:    state_nxt = ST_RELEASE;
        ST_RELEASE: if (tick_i && wdt_cnt_i == WDT_TOP) state_nxt = ST_RUN;
        ST_RUN: begin
          if (stop_req_i && wake_idle_i) state_nxt = ST_STOP;
          else if (!wdt_clr_i && tick_i && wdt_cnt_i == WDT_TOP) state_nxt = ST_WDRST;
        end
        ST_WDRST:   if (tick_i && wdt_cnt_i == PULSE_TOP) state_nxt = ST_RUN;
        ST_STOP:    if (!wake_idle_i) state_nxt = ST_STAB;
        ST_STAB:    if (tick_i && stab_cnt_i == STAB_TOP) state_nxt = ST_RUN;
        default:    state_nxt = ST_RELEASE;
      endcase
    end
  end

  always_comb begin
    wdt_clr_o = lvd_i || (state_nxt != state)
             || (state == ST_LOWV) || (state == ST_STOP) || (state == ST_STAB)
             || (state == ST_RUN && wdt_clr_i);
    wdt_inc_o = tick_i && ((state == ST_RELEASE) || (state == ST_RUN) || (state == ST_WDRST));
    stab_clr_o = (state != ST_STAB);
    stab_inc_o = tick_i && (state == ST_STAB);
  end

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      state       <= ST_RELEASE;
      sys_rst_n_o <= 1'b0;
      osc_en_o    <= 1'b1;
      run_en_o    <= 1'b0;
      port_stop_o <= 1'b0;
    end else begin
      state       <= state_nxt;
      sys_rst_n_o <= (state_nxt == ST_RUN) || (state_nxt == ST_STOP) || (state_nxt == ST_STAB);
      osc_en_o    <= (state_nxt != ST_STOP);
      run_en_o    <= (state_nxt == ST_RUN);
      port_stop_o <= (state_nxt == ST_STOP);
    end
  end
endmodule

// File: rtl/wdg_stop_rstctl.sv
module wdg_stop_rstctl #(
  parameter int WAKE_W    = 6,
  parameter int WDT_BITS  = 14,
  parameter int STAB_BIT  = 10,
  parameter int RST_TICKS = 16,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              por_i,
  input  logic              tick_i,
  input  logic              wdt_clr_i,
  input  logic              stop_req_i,
  input  logic              lvd_i,
  input  logic [WAKE_W-1:0] wake_n_i,
  output logic              sys_rst_n_o,
  output logic              osc_en_o,
  output logic              run_en_o,
  output logic              port_stop_o
);
  localparam int STAB_W = STAB_BIT + 1;

  logic [WAKE_W-1:0]   wake_s;
  logic [WDT_BITS-1:0] wdt_cnt;
  logic [STAB_W-1:0]   stab_cnt;
  logic                wdt_clr, wdt_inc, stab_clr, stab_inc;

  rsc_sync #(.W(WAKE_W), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .por_i(por_i), .d_i(wake_n_i), .q_o(wake_s)
  );

  rsc_counter #(.W(WDT_BITS)) u_wdt (
    .clk(clk), .por_i(por_i), .clr_i(wdt_clr), .inc_i(wdt_inc), .cnt_o(wdt_cnt)
  );

  rsc_counter #(.W(STAB_W)) u_stab (
    .clk(clk), .por_i(por_i), .clr_i(stab_clr), .inc_i(stab_inc), .cnt_o(stab_cnt)
  );

  rsc_seq #(.WDT_BITS(WDT_BITS), .STAB_BIT(STAB_BIT), .RST_TICKS(RST_TICKS)) u_seq (
    .clk(clk), .por_i(por_i), .lvd_i(lvd_i), .tick_i(tick_i),
    .wdt_clr_i(wdt_clr_i), .stop_req_i(stop_req_i), .wake_idle_i(&wake_s),
    .wdt_cnt_i(wdt_cnt), .stab_cnt_i(stab_cnt),
    .wdt_clr_o(wdt_clr), .wdt_inc_o(wdt_inc), .stab_clr_o(stab_clr), .stab_inc_o(stab_inc),
    .sys_rst_n_o(sys_rst_n_o), .osc_en_o(osc_en_o), .run_en_o(run_en_o),
    .port_stop_o(port_stop_o)
  );
endmodule

// File: rtl/wdg_stop_rstctl_chk.sv
module wdg_stop_rstctl_chk #(
  parameter int WAKE_W   = 6,
  parameter int WDT_BITS = 14
) (
  input logic                clk,
  input logic                por_i,
  input logic                tick_i,
  input logic                stop_req_i,
  input logic                lvd_i,
  input logic [WAKE_W-1:0]   wake_n_i,
  input logic                sys_rst_n_o,
  input logic                osc_en_o,
  input logic                run_en_o,
  input logic                port_stop_o,
  input logic [WDT_BITS-1:0] wdt_cnt
);
  p_lvd_forces_reset_r6: assert property (@(posedge clk) disable iff (por_i)
    lvd_i |=> !sys_rst_n_o);

  p_lvd_clears_count_r4: assert property (@(posedge clk) disable iff (por_i)
    lvd_i |=> wdt_cnt == '0);

  p_stop_outputs_r7: assert property (@(posedge clk) disable iff (por_i)
    port_stop_o |-> (!osc_en_o && !run_en_o && sys_rst_n_o && wdt_cnt == '0));

  p_run_only_out_of_reset_r1: assert property (@(posedge clk) disable iff (por_i)
    run_en_o |-> sys_rst_n_o);

  p_stop_noop_r8: assert property (@(posedge clk) disable iff (por_i)
    (run_en_o && stop_req_i && !tick_i && !lvd_i && !(&wake_n_i)
     && $past(wake_n_i) == wake_n_i && $past(wake_n_i, 2) == wake_n_i)
    |=> (run_en_o && !port_stop_o));

  p_wake_enters_stab_r9: assert property (@(posedge clk) disable iff (por_i)
    $fell(port_stop_o) |-> (osc_en_o && !run_en_o));
endmodule

bind wdg_stop_rstctl wdg_stop_rstctl_chk #(.WAKE_W(WAKE_W), .WDT_BITS(WDT_BITS)) u_chk (
  .clk(clk), .por_i(por_i), .tick_i(tick_i), .stop_req_i(stop_req_i), .lvd_i(lvd_i),
  .wake_n_i(wake_n_i), .sys_rst_n_o(sys_rst_n_o), .osc_en_o(osc_en_o),
  .run_en_o(run_en_o), .port_stop_o(port_stop_o), .wdt_cnt(wdt_cnt)
);

// File: tb/tb_wdg_stop_rstctl.sv
`timescale 1ns/1ps
module tb_wdg_stop_rstctl;
  localparam int WAKE_W   = 6;
  localparam int WDT_TICK = 1 << 13;
  localparam int STAB_TK  = 1 << 10;
  localparam int PULSE_TK = 16;

  logic clk = 1'b0;
  logic por_i = 1'b1, tick_i = 1'b0, wdt_clr_i = 1'b0, stop_req_i = 1'b0, lvd_i = 1'b0;
  logic [WAKE_W-1:0] wake_n_i = '1;
  logic sys_rst_n_o, osc_en_o, run_en_o, port_stop_o;

  int checks = 0;
  int fails  = 0;
  int unsigned cycles = 0;

  always #2 clk = ~clk;

  wdg_stop_rstctl #(.WAKE_W(WAKE_W)) dut (
    .clk(clk), .por_i(por_i), .tick_i(tick_i), .wdt_clr_i(wdt_clr_i),
    .stop_req_i(stop_req_i), .lvd_i(lvd_i), .wake_n_i(wake_n_i),
    .sys_rst_n_o(sys_rst_n_o), .osc_en_o(osc_en_o), .run_en_o(run_en_o),
    .port_stop_o(port_stop_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired: actual cycles %0d expected < 190000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one clock: inputs already set, tick level given, returns at the next negedge
  task automatic cyc(input bit t);
    tick_i = t;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  // n ticks with random idle gaps; ends just after the edge of the last tick
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      if ($urandom_range(0, 3) == 0) cyc(1'b0);
      cyc(1'b1);
    end
  endtask

  function automatic logic [WAKE_W-1:0] one_low(input int b);
    logic [WAKE_W-1:0] v = '1;
    v[b] = 1'b0;
    return v;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rst_n", int'(sys_rst_n_o), 0);
    chk("R1 run_en", int'(run_en_o), 0);
    chk("R1 osc_en", int'(osc_en_o), 1);
    chk("R1 port_stop", int'(port_stop_o), 0);
    por_i = 1'b0;
    cyc(1'b0);

    // R2 release after power-on
    ticks(WDT_TICK - 1);
    chk("R2 held before last tick", int'(sys_rst_n_o), 0);
    ticks(1);
    chk("R2 released", int'(sys_rst_n_o), 1);
    chk("R2 run_en", int'(run_en_o), 1);

    // R4 random clear intervals keep the core running
    for (int k = 0; k < 4; k++) begin
      ticks($urandom_range(500, WDT_TICK - 100));
      chk("R4 running before clear", int'(run_en_o), 1);
      wdt_clr_i = 1'b1; cyc(1'b0); wdt_clr_i = 1'b0;
    end
    repeat (20) cyc(1'b0);
    ticks(8000);
    wdt_clr_i = 1'b1; cyc(1'b0); wdt_clr_i = 1'b0;
    ticks(WDT_TICK - 1);
    chk("R4 full window after clear", int'(sys_rst_n_o), 1);
    // R3 timeout
    ticks(1);
    chk("R3 timeout rst_n", int'(sys_rst_n_o), 0);
    chk("R3 timeout run_en", int'(run_en_o), 0);
    // R5 pulse length and restart
    ticks(PULSE_TK - 1);
    chk("R5 pulse still low", int'(sys_rst_n_o), 0);
    ticks(1);
    chk("R5 pulse ended", int'(sys_rst_n_o), 1);
    ticks(WDT_TICK - 1);
    chk("R5 restart from zero", int'(run_en_o), 1);
    wdt_clr_i = 1'b1; cyc(1'b0); wdt_clr_i = 1'b0;

    // R8 stop with a key held low is a no-op
    begin
      int b = $urandom_range(0, WAKE_W - 1);
      wake_n_i = one_low(b);
      repeat (3) cyc(1'b0);
      stop_req_i = 1'b1; cyc(1'b0); stop_req_i = 1'b0;
      chk("R8 run_en kept", int'(run_en_o), 1);
      chk("R8 no stop", int'(port_stop_o), 0);
      wake_n_i = '1;
      repeat (3) cyc(1'b0);
    end

    // R7 stop entry, ticks ignored
    stop_req_i = 1'b1; cyc(1'b0); stop_req_i = 1'b0;
    chk("R7 port_stop", int'(port_stop_o), 1);
    chk("R7 osc_en off", int'(osc_en_o), 0);
    chk("R7 run_en off", int'(run_en_o), 0);
    ticks(WDT_TICK + 2000);
    chk("R7 no reset in stop", int'(sys_rst_n_o), 1);
    chk("R7 still stopped", int'(port_stop_o), 1);

    // R9 wake through synchroniser then stabilisation
    wake_n_i = one_low($urandom_range(0, WAKE_W - 1));
    cyc(1'b0); cyc(1'b0);
    chk("R9 stop after two edges", int'(port_stop_o), 1);
    cyc(1'b0);
    chk("R9 left stop", int'(port_stop_o), 0);
    chk("R9 osc_en on", int'(osc_en_o), 1);
    chk("R9 run_en waits", int'(run_en_o), 0);
    wake_n_i = '1;
    ticks(STAB_TK - 1);
    chk("R9 still stabilising", int'(run_en_o), 0);
    ticks(1);
    chk("R9 run resumes", int'(run_en_o), 1);

    // R10 watchdog from zero after wake
    ticks(WDT_TICK - 1);
    chk("R10 no early timeout", int'(sys_rst_n_o), 1);
    ticks(1);
    chk("R10 timeout at full window", int'(sys_rst_n_o), 0);
    ticks(PULSE_TK);
    chk("R5 second pulse ended", int'(sys_rst_n_o), 1);

    // R6 low supply
    ticks(100);
    lvd_i = 1'b1; cyc(1'b0);
    chk("R6 reset on low supply", int'(sys_rst_n_o), 0);
    ticks(WDT_TICK + 800);
    chk("R6 held while low", int'(sys_rst_n_o), 0);
    lvd_i = 1'b0; cyc(1'b0);
    ticks(WDT_TICK - 1);
    chk("R6 held before count done", int'(sys_rst_n_o), 0);
    ticks(1);
    chk("R6 released", int'(sys_rst_n_o), 1);
    chk("R6 run_en", int'(run_en_o), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule